// File: doc/BRIEF.md
# Clock-loss keepalive power-down controller

This block decides when a chip should drop into its low-power keepalive state. A free-running reference clock watches the fast main clock. The main clock drives a divide-by-two toggle. That toggle is synchronized into the reference domain, and every edge that arrives there restarts an idle counter. If the counter runs out, the main clock is taken to have stopped, and the block enters power-down on its own. A software power-down bit forces the same state at any time. A keepalive-disable bit stops the automatic entry but leaves the software bit working.

While power-down is active, the per-cycle clock enable is replaced by a slow refresh tick. The tick is one reference cycle wide and comes once per tick period, about 1 ms at the default parameters. This keeps internal dynamic state refreshed. When the main clock comes back and the idle counter has been below its limit for two reference cycles in a row, the automatic power-down ends. A sticky clock-lost flag records each automatic entry until software clears it with a one-cycle write-one-to-clear pulse.

The idle timeout and the tick period are parameters counted in reference cycles. The defaults assume a 1 MHz reference: 2000 cycles gives 2 ms and 1000 cycles gives 1 ms. All outputs and control inputs belong to the reference domain.

Top module: `clkloss_pwrdn_ctrl`

## Requirements
- R1: While reset is asserted and right after it is released, with the software bit low: pd_active is 0, clk_lost is 0 and tick_en is 1.
- R2: When sw_pd is 1 at a reference edge, pd_active is 1 from that edge on, whatever the value of ka_disable. pd_active falls at the edge after sw_pd returns to 0, unless automatic power-down is active.
- R3: During power-down, tick_en is a single-cycle pulse with a period of TICK_CYC reference cycles. After the edge at which power-down starts, the first pulse appears TICK_CYC-1 cycles later.
- R4: Outside power-down, tick_en is 1 in every reference cycle.
- R5: A running main clock never causes power-down. This holds for main clocks both faster and slower than the reference, as long as its divided toggle is not locked to a harmonic of the reference.
- R6: When the main clock stops and ka_disable is 0, pd_active rises between TIMEOUT_CYC-2 and TIMEOUT_CYC+8 reference cycles after the stop.
- R7: clk_lost becomes 1 on every automatic entry into power-down and never on a software-only entry. It stays 1 until a cycle in which lost_clr is 1, which clears it. An entry in that same cycle wins over the clear.
- R8: While ka_disable is 1, a stopped main clock neither causes power-down nor sets clk_lost. Raising ka_disable during automatic power-down ends it at the next reference edge.
- R9: After the main clock restarts, automatic power-down ends between 3 and 16 reference cycles later. If sw_pd is 1, pd_active stays 1 throughout.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| main_clk | input | 1 | Fast main clock being watched; it may stop |
| ref_clk | input | 1 | Free-running reference clock; all control logic runs on it |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously in each domain |
| sw_pd | input | 1 | Software power-down bit, synchronous to ref_clk |
| ka_disable | input | 1 | 1 disables automatic clock-loss entry into power-down |
| lost_clr | input | 1 | One-cycle pulse that clears clk_lost |
| pd_active | output | 1 | 1 while in power-down (software or automatic) |
| tick_en | output | 1 | Clock enable: 1 every cycle normally, slow refresh pulse in power-down |
| clk_lost | output | 1 | Sticky flag: automatic power-down has occurred |

## Verification
The assertions assume that sw_pd, ka_disable and lost_clr are synchronous to ref_clk. They also assume that TICK_CYC is at least 2 and that a running main clock gives synchronized toggle edges more often than every TIMEOUT_CYC cycles. The stimulus changes every control input on the falling reference edge. It sweeps the main half-period over 3, 7, 13 and 29 ns against an 8 ns reference. Those ratios keep the divided toggle off any exact multiple of the reference period. A locked ratio would freeze the sampled toggle, and the block would report a lost clock even though the main clock is running.

// File: rtl/ckl_pkg.sv
package ckl_pkg;
  typedef enum logic {
    ST_RUN     = 1'b0,
    ST_AUTO_PD = 1'b1
  } ckl_state_e;
endpackage

// File: rtl/ckl_rst_sync.sv
module ckl_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/ckl_act_toggle.sv
module ckl_act_toggle (
  input  logic main_clk,
  input  logic rst_n,
  output logic act_tgl
);
  logic tgl_q;
  logic tgl_d;

  always_comb tgl_d = ~tgl_q;

  always_ff @(posedge main_clk or negedge rst_n) begin
    if (!rst_n) tgl_q <= 1'b0;
    else        tgl_q <= tgl_d;
  end

  assign act_tgl = tgl_q;
endmodule

// File: rtl/ckl_act_monitor.sv
module ckl_act_monitor #(
  parameter int SYNC_STAGES = 2,
  parameter int TIMEOUT_CYC = 2000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic act_tgl,
  output logic stopped,
  output logic steady
);
  localparam int CNT_W = $clog2(TIMEOUT_CYC + 1);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(TIMEOUT_CYC);

  // synchronizer stages followed by one edge-reference stage
  logic [SYNC_STAGES:0] smp_q;
  logic [SYNC_STAGES:0] smp_d;

  always_comb smp_d[0] = act_tgl;
  for (genvar g = 1; g <= SYNC_STAGES; g++) begin : g_sync
    always_comb smp_d[g] = smp_q[g-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) smp_q <= '0;
    else        smp_q <= smp_d;
  end

  logic act_edge;
  always_comb act_edge = smp_q[SYNC_STAGES] ^ smp_q[SYNC_STAGES-1];

  logic [CNT_W-1:0] idle_q;
  logic [CNT_W-1:0] idle_d;
  logic             live_q;
  logic             live_d;

  always_comb begin
    idle_d = idle_q;
    if (act_edge)             idle_d = '0;
    else if (idle_q != LIMIT) idle_d = idle_q + 1'b1;
    live_d = (idle_q != LIMIT);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_q <= '0;
      live_q <= 1'b1;
    end else begin
      idle_q <= idle_d;
      live_q <= live_d;
    end
  end

  assign stopped = (idle_q == LIMIT);
  assign steady  = !stopped && live_q;

  // R5: a synchronized activity edge always clears the stopped state
  a_r5_edge_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    act_edge |=> !stopped);

  // R6: once stopped, only an activity edge leaves that state
  a_r6_stop_holds: assert property (@(posedge clk) disable iff (!rst_n)
    stopped && !act_edge |=> stopped);
endmodule

// File: rtl/ckl_tick_gen.sv
module ckl_tick_gen #(
  parameter int TICK_CYC = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pd_active,
  output logic tick_en
);
  localparam int TK_W = (TICK_CYC > 2) ? $clog2(TICK_CYC) : 1;
  localparam logic [TK_W-1:0] LAST = TK_W'(TICK_CYC - 1);

  logic [TK_W-1:0] cnt_q;
  logic [TK_W-1:0] cnt_d;

  always_comb begin
    if (!pd_active)         cnt_d = '0;
    else if (cnt_q == LAST) cnt_d = '0;
    else                    cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick_en = !pd_active || (cnt_q == LAST);

  // R4: full-rate enable outside power-down
  a_r4_full_rate: assert property (@(posedge clk) disable iff (!rst_n)
    !pd_active |-> tick_en);

  // R3: in power-down a refresh tick lasts one cycle only
  a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    pd_active && tick_en && $past(pd_active) |=> !(pd_active && tick_en) || !$past(pd_active));
endmodule

// File: rtl/clkloss_pwrdn_ctrl.sv
module clkloss_pwrdn_ctrl #(
  parameter int TIMEOUT_CYC = 2000,
  parameter int TICK_CYC    = 1000,
  parameter int SYNC_STAGES = 2
) (
  input  logic main_clk,
  input  logic ref_clk,
  input  logic rst_n,
  input  logic sw_pd,
  input  logic ka_disable,
  input  logic lost_clr,
  output logic pd_active,
  output logic tick_en,
  output logic clk_lost
);
  import ckl_pkg::*;

  logic main_rst_n;
  logic ref_rst_n;
  logic act_tgl;
  logic stopped;
  logic steady;

  ckl_rst_sync #(.STAGES(2)) u_rst_main (
    .clk(main_clk), .arst_n(rst_n), .srst_n(main_rst_n));

  ckl_rst_sync #(.STAGES(2)) u_rst_ref (
    .clk(ref_clk), .arst_n(rst_n), .srst_n(ref_rst_n));

  ckl_act_toggle u_toggle (
    .main_clk(main_clk), .rst_n(main_rst_n), .act_tgl(act_tgl));

  ckl_act_monitor #(.SYNC_STAGES(SYNC_STAGES), .TIMEOUT_CYC(TIMEOUT_CYC)) u_mon (
    .clk(ref_clk), .rst_n(ref_rst_n), .act_tgl(act_tgl),
    .stopped(stopped), .steady(steady));

  ckl_state_e state_q;
  ckl_state_e state_d;
  logic       sw_q;
  logic       lost_q;
  logic       lost_d;
  logic       auto_enter;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_RUN:     if (!ka_disable && stopped) state_d = ST_AUTO_PD;
      ST_AUTO_PD: if (ka_disable || steady)   state_d = ST_RUN;
      default:    state_d = ST_RUN;
    endcase
    auto_enter = (state_q == ST_RUN) && (state_d == ST_AUTO_PD);
    if (auto_enter)    lost_d = 1'b1;
    else if (lost_clr) lost_d = 1'b0;
    else               lost_d = lost_q;
  end

  always_ff @(posedge ref_clk or negedge ref_rst_n) begin
    if (!ref_rst_n) begin
      state_q <= ST_RUN;
      sw_q    <= 1'b0;
      lost_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      sw_q    <= sw_pd;
      lost_q  <= lost_d;
    end
  end

  assign pd_active = sw_q || (state_q == ST_AUTO_PD);
  assign clk_lost  = lost_q;

  ckl_tick_gen #(.TICK_CYC(TICK_CYC)) u_tick (
    .clk(ref_clk), .rst_n(ref_rst_n), .pd_active(pd_active), .tick_en(tick_en));

  // R2: the software bit forces power-down one edge after it is seen
  a_r2_sw_forces: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
    $past(ref_rst_n) && $past(sw_pd) |-> pd_active);

  // R6: automatic entry only after the monitor reported a stopped clock
  a_r6_entry_needs_stop: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
    $rose(clk_lost) |-> $past(stopped) && !$past(ka_disable));

  // R7: clk_lost stays set unless cleared
  a_r7_lost_sticky: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
    clk_lost && !lost_clr |=> clk_lost);

  // R8: no automatic entry while detection is disabled
  a_r8_disabled_no_entry: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
    ka_disable |=> !$rose(clk_lost));

  // R9: leaving automatic power-down needs activity or disable
  a_r9_exit_cause: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
    $fell(state_q) |-> $past(steady) || $past(ka_disable));
endmodule

// File: tb/clkloss_pwrdn_ctrl_tb.sv
`timescale 1ns/1ps
module clkloss_pwrdn_ctrl_tb;
  localparam int TMO  = 40;
  localparam int TICK = 10;

  logic main_clk, ref_clk, rst_n, sw_pd, ka_disable, lost_clr;
  logic pd_active, tick_en, clk_lost;

  int  checks = 0;
  int  errors = 0;
  bit  done   = 0;
  bit  main_run = 1;
  int  main_half = 7;

  clkloss_pwrdn_ctrl #(.TIMEOUT_CYC(TMO), .TICK_CYC(TICK), .SYNC_STAGES(2)) u_dut (
    .main_clk(main_clk), .ref_clk(ref_clk), .rst_n(rst_n), .sw_pd(sw_pd),
    .ka_disable(ka_disable), .lost_clr(lost_clr),
    .pd_active(pd_active), .tick_en(tick_en), .clk_lost(clk_lost));

  initial ref_clk = 0;
  always #4 ref_clk = ~ref_clk;

  initial main_clk = 0;
  always begin
    #(main_half);
    if (main_run) main_clk = ~main_clk;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge ref_clk);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  // watchdog
  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      summary();
      $finish;
    end
  end

  initial begin
    int bad, n, gap;
    int halves[4] = '{3, 7, 13, 29};
    rst_n = 0; sw_pd = 0; ka_disable = 0; lost_clr = 0;
    cyc(3);
    chk(pd_active == 0 && clk_lost == 0 && tick_en == 1, "R1 in reset",
        {pd_active, clk_lost, tick_en}, 3'b001);
    rst_n = 1;
    cyc(4);
    chk(pd_active == 0 && clk_lost == 0 && tick_en == 1, "R1 after release",
        {pd_active, clk_lost, tick_en}, 3'b001);

    // R4/R5 sweep over main clock rates
    foreach (halves[k]) begin
      main_half = halves[k];
      bad = 0;
      for (int i = 0; i < 3 * TMO; i++) begin
        @(negedge ref_clk);
        if (pd_active || !tick_en) bad++;
      end
      chk(bad == 0, $sformatf("R5/R4 running half=%0d", halves[k]), bad, 0);
    end
    main_half = 7;

    // R2/R3 software power-down, detection enabled then disabled
    for (int d = 0; d < 2; d++) begin
      ka_disable = d[0];
      sw_pd = 1;
      @(posedge ref_clk);
      bad = 0;
      for (int i = 0; i < 3 * TICK; i++) begin
        @(negedge ref_clk);
        if (!pd_active) bad++;
        if (tick_en != (((i + 1) % TICK) == 0)) bad++;
      end
      chk(bad == 0, $sformatf("R2/R3 sw pd tick pattern kad=%0d", d), bad, 0);
      chk(clk_lost == 0, "R7 sw entry leaves clk_lost clear", clk_lost, 0);
      sw_pd = 0;
      cyc(2);
      chk(pd_active == 0 && tick_en == 1, "R2 sw release", {pd_active, tick_en}, 2'b01);
    end
    ka_disable = 0;

    // R6 clock stop timeout
    main_run = 0;
    n = 0;
    while (!pd_active && n < 4 * TMO) begin
      @(negedge ref_clk);
      n++;
    end
    chk(n >= TMO - 2 && n <= TMO + 8, "R6 timeout window", n, TMO);
    chk(clk_lost == 1, "R7 auto entry sets clk_lost", clk_lost, 1);
    while (!tick_en) @(negedge ref_clk);
    gap = 0;
    do begin
      @(negedge ref_clk);
      gap++;
    end while (!tick_en && gap < 4 * TICK);
    chk(gap == TICK, "R3 auto pd tick period", gap, TICK);

    // R9 recovery with sw bit held, R7 sticky and clear
    sw_pd = 1;
    cyc(1);
    main_run = 1;
    bad = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge ref_clk);
      if (!pd_active) bad++;
    end
    chk(bad == 0, "R9 sw holds pd during recovery", bad, 0);
    chk(clk_lost == 1, "R7 clk_lost sticky", clk_lost, 1);
    sw_pd = 0;
    cyc(2);
    chk(pd_active == 0, "R9 auto pd ended after restart", pd_active, 0);
    lost_clr = 1;
    cyc(1);
    lost_clr = 0;
    cyc(1);
    chk(clk_lost == 0, "R7 lost_clr clears", clk_lost, 0);

    // R9 plain recovery timing
    main_run = 0;
    cyc(TMO + 12);
    chk(pd_active == 1, "R6 second stop enters pd", pd_active, 1);
    main_run = 1;
    n = 0;
    while (pd_active && n < 40) begin
      @(negedge ref_clk);
      n++;
    end
    chk(n >= 3 && n <= 16, "R9 recovery window", n, 8);
    lost_clr = 1; cyc(1); lost_clr = 0; cyc(1);

    // R8 detection disabled
    ka_disable = 1;
    main_run = 0;
    bad = 0;
    for (int i = 0; i < 3 * TMO; i++) begin
      @(negedge ref_clk);
      if (pd_active || clk_lost || !tick_en) bad++;
    end
    chk(bad == 0, "R8 disabled stop ignored", bad, 0);
    ka_disable = 0;
    cyc(2);
    chk(pd_active == 1 && clk_lost == 1, "R8 re-enable enters pd",
        {pd_active, clk_lost}, 2'b11);
    ka_disable = 1;
    cyc(2);
    chk(pd_active == 0 && tick_en == 1, "R8 disable releases auto pd",
        {pd_active, tick_en}, 2'b01);
    ka_disable = 0;
    main_run = 1;
    cyc(10);

    done = 1;
    summary();
    $finish;
  end
endmodule